// File: doc/BRIEF.md
# Modular Butterfly Processing Element

This block is the shared arithmetic engine of a number-theoretic-transform polynomial multiplier working modulo a prime `PRIME`. Each cycle it can accept one operand set `(c, d, w)` of residues in the range 0 to PRIME−1. In butterfly mode it multiplies the twiddle factor by the second operand and reduces the product modulo the prime. It then returns both the modular sum with `c` and the modular difference from `c`. The same pipeline also serves as a plain modular multiplier, for pointwise products and for scaling by n⁻¹ and ψ⁻ⁱ, and as a plain modular adder/subtracter. This keeps the expensive multiplier busy in every phase of a polynomial product.

The prime is fixed when the design is built. When it is the Fermat prime 65537, a shift-and-subtract reduction that uses 2¹⁶ ≡ −1 is elaborated in place of the generic Barrett reduction. The operand width is ceil(log2 PRIME), so 17 bits for 65537. Every mode has the same three-cycle latency, and a valid flag travels with the data.

Top module: `ntt_bfly_unit`

## Requirements
- R1: With mode code 2'b00 (the unused code 2'b11 behaves the same), `sum_o` equals (c + w·d) mod PRIME.
- R2: With mode code 2'b00, `diff_o` equals (c − w·d) mod PRIME, taken in the range 0 to PRIME−1.
- R3: Whenever `out_valid_o` is high, `sum_o` and `diff_o` both lie in 0 to PRIME−1, given inputs in that range.
- R4: With mode code 2'b01 (multiply), `sum_o` equals (w·d) mod PRIME and `diff_o` equals (PRIME − sum_o) mod PRIME; the value on `c_i` has no effect.
- R5: With mode code 2'b10 (add), `sum_o` equals (c + d) mod PRIME and `diff_o` equals (c − d) mod PRIME; the value on `w_i` has no effect.
- R6: An operand set taken with `in_valid_i` high at a rising edge produces its result with `out_valid_o` high exactly three rising edges later, in every mode. Back-to-back operand sets are accepted every cycle and come out in issue order. `out_valid_o` is never high without a matching input three cycles earlier.
- R7: While `rst_n` is low, `out_valid_o`, `sum_o` and `diff_o` are all zero.
- R8: For PRIME = 65537 the Fermat reduction is used. The reduced product is always below PRIME, including the extreme operand 65536, where 65536·65536 reduces to 1.
- R9: While `out_valid_o` is low, `sum_o` and `diff_o` keep their last values, whatever is applied to the inputs with `in_valid_i` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Operand set on the inputs is taken this cycle |
| mode_i | input | 2 | 00 butterfly, 01 multiply, 10 add, 11 treated as butterfly |
| c_i | input | W | Additive operand, residue below PRIME |
| d_i | input | W | Multiplied operand (second addend in add mode) |
| w_i | input | W | Twiddle factor / multiplier constant |
| out_valid_o | output | 1 | Result on the outputs is valid |
| sum_o | output | W | Modular sum output |
| diff_o | output | W | Modular difference output |

## Verification
On every cycle, the assertions check the output range and the reduced-product range. They also check the exact three-cycle pairing between input and output valid flags, and that the outputs hold while no result is presented. The arithmetic itself is shown only by the bench scenarios. These compare each output against an independently computed modular model in all three modes. The scenarios cover the extreme Fermat operand 65536, wrap-around of sums and differences, and that `c_i` or `w_i` is ignored in the modes that do not use it. They also drive a back-to-back stream to show single-cycle throughput and ordering.

// File: rtl/ntt_bfly_pkg.sv
package ntt_bfly_pkg;

  // Operation select for the processing element.
  typedef enum logic [1:0] {
    BF_MODE_BFLY = 2'b00,
    BF_MODE_MUL  = 2'b01,
    BF_MODE_ADD  = 2'b10,
    BF_MODE_RSVD = 2'b11
  } bf_mode_e;

  localparam int unsigned FERMAT_PRIME = 65537;
  localparam int unsigned BF_LATENCY   = 3;

endpackage

// File: rtl/bfly_mult_stage.sv
// Stage 1: multiply w*d, or pass d / zero c depending on the mode.
module bfly_mult_stage
  import ntt_bfly_pkg::*;
#(
  parameter int W = 17
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            vld_i,
  input  bf_mode_e        mode_i,
  input  logic [W-1:0]    c_i,
  input  logic [W-1:0]    d_i,
  input  logic [W-1:0]    w_i,
  output logic            vld_o,
  output bf_mode_e        mode_o,
  output logic [W-1:0]    c_o,
  output logic [2*W-1:0]  prod_o
);

  localparam int PW = 2 * W;

  logic [PW-1:0] prod_d;
  logic [W-1:0]  c_d;

  always_comb begin
    unique case (mode_i)
      BF_MODE_ADD: begin
        prod_d = {{W{1'b0}}, d_i};
        c_d    = c_i;
      end
      BF_MODE_MUL: begin
        prod_d = w_i * d_i;
        c_d    = '0;
      end
      default: begin
        prod_d = w_i * d_i;
        c_d    = c_i;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_o  <= 1'b0;
      mode_o <= BF_MODE_BFLY;
      c_o    <= '0;
      prod_o <= '0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) begin
        mode_o <= mode_i;
        c_o    <= c_d;
        prod_o <= prod_d;
      end
    end
  end

endmodule

// File: rtl/bfly_reduce_stage.sv
// Stage 2: reduce the double-width product modulo PRIME.
module bfly_reduce_stage
  import ntt_bfly_pkg::*;
#(
  parameter int unsigned PRIME = 65537,
  parameter int          W     = 17
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            vld_i,
  input  bf_mode_e        mode_i,
  input  logic [W-1:0]    c_i,
  input  logic [2*W-1:0]  prod_i,
  output logic            vld_o,
  output bf_mode_e        mode_o,
  output logic [W-1:0]    c_o,
  output logic [W-1:0]    red_o
);

  localparam int PW = 2 * W;

  logic [W-1:0] red_d;

  generate
    if (PRIME == FERMAT_PRIME) begin : g_fermat
      // x = hi*2^16 + lo and 2^16 == -1 (mod p), so x == lo - hi.
      function automatic logic [W-1:0] fermat_reduce(input logic [PW-1:0] x);
        logic [PW-16:0] lo;
        logic [PW-16:0] hi;
        logic [PW-16:0] r;
        lo = {{(PW-15){1'b0}}, x[15:0]};
        hi = {1'b0, x[PW-1:16]};
        if (lo >= hi) r = lo - hi;
        else          r = lo + (PW-15)'(FERMAT_PRIME) - hi;
        return r[W-1:0];
      endfunction

      assign red_d = fermat_reduce(prod_i);
    end else begin : g_barrett
      localparam logic [PW:0] P_X = (PW+1)'(PRIME);
      localparam logic [PW:0] MU  = ({{PW{1'b0}}, 1'b1} << PW) / P_X;

      // Barrett estimate undershoots the quotient by at most two.
      function automatic logic [W-1:0] barrett_reduce(input logic [PW-1:0] x);
        logic [2*PW+1:0] t;
        logic [PW-1:0]   q;
        logic [PW-1:0]   rem;
        logic [W+1:0]    r;
        t   = {{(PW+2){1'b0}}, x} * {{(PW+1){1'b0}}, MU};
        q   = t[2*PW-1:PW];
        rem = x - PW'(q * P_X[PW-1:0]);
        r   = rem[W+1:0];
        if (r >= (W+2)'(PRIME)) r = r - (W+2)'(PRIME);
        if (r >= (W+2)'(PRIME)) r = r - (W+2)'(PRIME);
        return r[W-1:0];
      endfunction

      assign red_d = barrett_reduce(prod_i);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_o  <= 1'b0;
      mode_o <= BF_MODE_BFLY;
      c_o    <= '0;
      red_o  <= '0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) begin
        mode_o <= mode_i;
        c_o    <= c_i;
        red_o  <= red_d;
      end
    end
  end

endmodule

// File: rtl/bfly_addsub_stage.sv
// Stage 3: modular sum and difference of c with the reduced product.
module bfly_addsub_stage #(
  parameter int unsigned PRIME = 65537,
  parameter int          W     = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vld_i,
  input  logic [W-1:0]  c_i,
  input  logic [W-1:0]  m_i,
  output logic          vld_o,
  output logic [W-1:0]  sum_o,
  output logic [W-1:0]  diff_o
);

  localparam logic [W:0] P_X = (W+1)'(PRIME);

  function automatic logic [W-1:0] mod_add(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W:0] s;
    s = {1'b0, a} + {1'b0, b};
    if (s >= P_X) s = s - P_X;
    return s[W-1:0];
  endfunction

  function automatic logic [W-1:0] mod_sub(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W:0] s;
    if (a >= b) s = {1'b0, a} - {1'b0, b};
    else        s = {1'b0, a} + P_X - {1'b0, b};
    return s[W-1:0];
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_o  <= 1'b0;
      sum_o  <= '0;
      diff_o <= '0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) begin
        sum_o  <= mod_add(c_i, m_i);
        diff_o <= mod_sub(c_i, m_i);
      end
    end
  end

endmodule

// File: rtl/ntt_bfly_unit.sv
module ntt_bfly_unit
  import ntt_bfly_pkg::*;
#(
  parameter int unsigned PRIME = 65537,
  parameter int          W     = $clog2(PRIME)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid_i,
  input  logic [1:0]    mode_i,
  input  logic [W-1:0]  c_i,
  input  logic [W-1:0]  d_i,
  input  logic [W-1:0]  w_i,
  output logic          out_valid_o,
  output logic [W-1:0]  sum_o,
  output logic [W-1:0]  diff_o
);

  // Inter-stage signals, named so the checker can observe them.
  logic            mul_vld;
  bf_mode_e        mul_mode;
  logic [W-1:0]    mul_c;
  logic [2*W-1:0]  mul_prod;
  logic            red_vld;
  bf_mode_e        red_mode;
  logic [W-1:0]    red_c;
  logic [W-1:0]    red_val;
  bf_mode_e        mode_in;

  assign mode_in = bf_mode_e'(mode_i);

  bfly_mult_stage #(.W(W)) u_mult (
    .clk    (clk),
    .rst_n  (rst_n),
    .vld_i  (in_valid_i),
    .mode_i (mode_in),
    .c_i    (c_i),
    .d_i    (d_i),
    .w_i    (w_i),
    .vld_o  (mul_vld),
    .mode_o (mul_mode),
    .c_o    (mul_c),
    .prod_o (mul_prod)
  );

  bfly_reduce_stage #(.PRIME(PRIME), .W(W)) u_red (
    .clk    (clk),
    .rst_n  (rst_n),
    .vld_i  (mul_vld),
    .mode_i (mul_mode),
    .c_i    (mul_c),
    .prod_i (mul_prod),
    .vld_o  (red_vld),
    .mode_o (red_mode),
    .c_o    (red_c),
    .red_o  (red_val)
  );

  bfly_addsub_stage #(.PRIME(PRIME), .W(W)) u_as (
    .clk    (clk),
    .rst_n  (rst_n),
    .vld_i  (red_vld),
    .c_i    (red_c),
    .m_i    (red_val),
    .vld_o  (out_valid_o),
    .sum_o  (sum_o),
    .diff_o (diff_o)
  );

endmodule

// File: rtl/ntt_bfly_checks.sv
module ntt_bfly_checks #(
  parameter int unsigned PRIME = 65537,
  parameter int          W     = 17
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          out_valid,
  input logic [W-1:0]  sum,
  input logic [W-1:0]  diff,
  input logic          red_vld,
  input logic [W-1:0]  red_val
);

  localparam logic [W:0] P_X = (W+1)'(PRIME);

  p_out_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (({1'b0, sum} < P_X) && ({1'b0, diff} < P_X)));

  p_red_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    red_vld |-> ({1'b0, red_val} < P_X));

  p_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ##2 out_valid);

  p_no_spurious_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid, 3));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> ($stable(sum) && $stable(diff)));

endmodule

bind ntt_bfly_unit ntt_bfly_checks #(.PRIME(PRIME), .W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid_i),
  .out_valid (out_valid_o),
  .sum       (sum_o),
  .diff      (diff_o),
  .red_vld   (red_vld),
  .red_val   (red_val)
);

// File: tb/sim_ntt_bfly_unit.sv
module sim_ntt_bfly_unit;

  localparam int P = 65537;
  localparam int W = 17;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid_i = 1'b0;
  logic [1:0]    mode_i = 2'b00;
  logic [W-1:0]  c_i = '0;
  logic [W-1:0]  d_i = '0;
  logic [W-1:0]  w_i = '0;
  logic          out_valid_o;
  logic [W-1:0]  sum_o;
  logic [W-1:0]  diff_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // Expected-result queue, indexed modulo 64.
  longint exp_s [64];
  longint exp_d [64];
  string  exp_tag [64];
  int wr_idx = 0;
  int rd_idx = 0;

  always #5 clk = ~clk;

  ntt_bfly_unit u0 (
    .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid_i), .mode_i(mode_i),
    .c_i(c_i), .d_i(d_i), .w_i(w_i),
    .out_valid_o(out_valid_o), .sum_o(sum_o), .diff_o(diff_o)
  );

  task automatic check(string req, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Independent reference: plain integer modular arithmetic.
  task automatic ref_model(int mode, longint c, longint d, longint w,
                           output longint s, output longint df);
    longint m;
    if (mode == 1) begin
      m = (w * d) % P;
      s = m;
      df = (P - m) % P;
    end else if (mode == 2) begin
      s = (c + d) % P;
      df = (c - d + P) % P;
    end else begin
      m = (w * d) % P;
      s = (c + m) % P;
      df = (c - m + P) % P;
    end
  endtask

  // Drive one operand set starting at a falling edge, hold for one cycle.
  task automatic issue(string tag, int mode, longint c, longint d, longint w);
    longint s, df;
    ref_model(mode, c, d, w, s, df);
    exp_s[wr_idx % 64] = s;
    exp_d[wr_idx % 64] = df;
    exp_tag[wr_idx % 64] = tag;
    wr_idx++;
    in_valid_i = 1'b1;
    mode_i = 2'(mode);
    c_i = W'(c);
    d_i = W'(d);
    w_i = W'(w);
    @(negedge clk);
    in_valid_i = 1'b0;
  endtask

  task automatic drain();
    for (int k = 0; k < 20 && rd_idx != wr_idx; k++) @(negedge clk);
    check("R6 all results delivered", rd_idx, wr_idx);
  endtask

  // Monitor: compare each valid result against the queue head.
  always @(negedge clk) begin
    if (rst_n && out_valid_o) begin
      if (rd_idx >= wr_idx) begin
        check("R6 unexpected out_valid", 1, 0);
      end else begin
        check({exp_tag[rd_idx % 64], " sum"}, sum_o, exp_s[rd_idx % 64]);
        check({exp_tag[rd_idx % 64], " diff"}, diff_o, exp_d[rd_idx % 64]);
        rd_idx++;
      end
    end
  end

  task automatic t_reset();
    check("R7 out_valid in reset", out_valid_o, 0);
    check("R7 sum in reset", sum_o, 0);
    check("R7 diff in reset", diff_o, 0);
  endtask

  task automatic t_butterfly();
    issue("R1/R2 bfly small", 0, 5, 3, 7);
    issue("R1/R2 bfly wrap", 0, 65536, 65536, 65536);
    issue("R8 fermat max operand", 0, 0, 1, 65536);
    issue("R1/R2 bfly zero product", 0, 1, 0, 12345);
    issue("R1/R2 reserved code as bfly", 3, 40000, 50000, 60000);
    drain();
  endtask

  task automatic t_multiply();
    issue("R4 mul c ignored", 1, 1234, 400, 300);
    issue("R4 mul c ignored max", 1, 65536, 65536, 65536);
    issue("R4 mul zero", 1, 777, 0, 9);
    drain();
  endtask

  task automatic t_add();
    issue("R5 add w ignored wrap", 2, 65000, 1000, 999);
    issue("R5 add borrow", 2, 10, 20, 65536);
    issue("R5 add max", 2, 65536, 65536, 0);
    drain();
  endtask

  task automatic t_stream();
    for (int i = 0; i < 12; i++)
      issue("R6 stream", i % 3, (i * 40503 + 7) % P, (i * 9973 + 65530) % P,
            (i * 31337 + 3) % P);
    drain();
  endtask

  task automatic t_latency();
    int cnt;
    cnt = 0;
    issue("R6 latency", 0, 100, 200, 300);
    // issue returned one falling edge after the launch; one rising edge passed.
    cnt = 1;
    while (!out_valid_o && cnt < 10) begin
      @(posedge clk);
      #1;
      cnt++;
    end
    check("R6 latency in rising edges", cnt, 3);
    drain();
  endtask

  task automatic t_hold();
    logic [W-1:0] s0, d0;
    @(negedge clk);
    s0 = sum_o;
    d0 = diff_o;
    for (int k = 0; k < 6; k++) begin
      mode_i = 2'(k % 3);
      c_i = W'(k * 1111);
      d_i = W'(k * 2222 + 5);
      w_i = W'(k * 3333 + 9);
      @(negedge clk);
    end
    check("R9 sum held while idle", sum_o, s0);
    check("R9 diff held while idle", diff_o, d0);
    check("R9 no valid while idle", out_valid_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_butterfly();
    t_multiply();
    t_add();
    t_stream();
    t_latency();
    t_hold();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule